// File: doc/BRIEF.md
# Programmable Static-Memory Access Sequencer

This block turns single requests from an internal master into timed strobe sequences for an external asynchronous SRAM or NOR flash. A request carries a direction flag, an address and, for writes, a data word. Once accepted, the access runs through a fixed order of phases: address setup, address hold, data setup, then bus turnaround. Each phase has a length that software programs through dedicated timing inputs. Chip-select, output-enable and write-enable are derived from the current phase. Read data is taken from the memory data pins on the last data-setup cycle.

When an access has the same direction as the access before it, the block first runs an idle gap phase before address setup. Separate lengths apply for read-after-read and for write-after-write. This keeps the bus quiet between like accesses. When the direction changes, and for the first access after reset, no gap is added. All timing inputs are sampled at the moment a request is accepted, so they may change freely while an access is in flight.

Top module: `smem_seq`

## Requirements
- R1: While reset is applied and directly after it is released, req_ready is 1, mem_cs_n, mem_oe_n and mem_we_n are 1, rd_valid is 0 and mem_dout_en is 0.
- R2: An accepted access holds mem_cs_n low for (A+1)+(H+1)+(D+1) consecutive cycles, where A, H and D are the 4-bit address-setup, address-hold and data-setup codes. mem_addr stays constant at the request address for the whole window.
- R3: For a write, mem_we_n is low, and for a read mem_oe_n is low, for exactly the last D+1 cycles of the chip-select window. The other strobe stays high, and the two strobes are never low together.
- R4: After chip-select rises, the sequencer stays busy with mem_cs_n high for T+1 cycles, where T is the 4-bit turnaround code (1 to 16 cycles). It then returns req_ready high.
- R5: For a read, rd_valid is high for exactly one cycle, the first turnaround cycle. In that cycle rd_data equals the value on mem_din during the final data-setup cycle.
- R6: For a write, mem_dout equals the request write data and mem_dout_en is 1 throughout the chip-select window. For a read, mem_dout_en is 0.
- R7: A read accepted after a read first spends G+1 idle cycles with mem_cs_n high, where G is the 8-bit read-after-read code (1 to 256 cycles).
- R8: A write accepted after a write first spends W+1 idle cycles with mem_cs_n high, where W is the 8-bit write-after-write code (1 to 256 cycles).
- R9: The first access after reset, and any access whose direction differs from the previous one, drives mem_cs_n low in the first cycle after acceptance.
- R10: All timing codes are sampled in the accepting cycle. Changing them later has no effect on that access.
- R11: req_ready is low from the cycle after acceptance until the turnaround phase ends. A request is accepted on a rising clock edge where req_valid and req_ready are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Sequencer idle, request may be accepted |
| rd_valid | output | 1 | One-cycle pulse, read data available |
| rd_data | output | DW | Captured read data |
| cfg_adr_setup | input | 4 | Address setup code A |
| cfg_adr_hold | input | 4 | Address hold code H |
| cfg_dat_setup | input | 4 | Data setup code D |
| cfg_turnaround | input | 4 | Turnaround code T |
| cfg_rr_gap | input | 8 | Read-after-read gap code G |
| cfg_ww_gap | input | 8 | Write-after-write gap code W |
| mem_addr | output | AW | Memory address pins |
| mem_dout | output | DW | Memory data out |
| mem_dout_en | output | 1 | Data pin output enable |
| mem_din | input | DW | Memory data in |
| mem_cs_n | output | 1 | Chip-select, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_we_n | output | 1 | Write-enable, active low |

## Verification
The phase codes are swept over combinations of minimum, middle and maximum values, with the direction alternating so that no gap phase occurs. This separates each phase length from the others by counting the chip-select, strobe and turnaround windows on their own. Gap codes from 0 to 255 are then tried on read-read and write-write pairs, with the opposite gap code set to a distinct value, so that a swapped or missing gap selection shows as a wrong idle count. Mixed-direction pairs confirm that no gap is added. Every timing input is inverted right after acceptance, so any late sampling changes a measured length.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam int PH_W  = 4;
  localparam int GAP_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_GAP, PH_ASET, PH_AHLD, PH_DATA, PH_TURN
  } phase_e;

  typedef struct packed {
    logic [PH_W-1:0] aset;
    logic [PH_W-1:0] ahld;
    logic [PH_W-1:0] dset;
    logic [PH_W-1:0] turn;
  } tcfg_t;

  function automatic logic [GAP_W-1:0] zx(input logic [PH_W-1:0] v);
    return {{(GAP_W-PH_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/smem_down_cnt.sv
module smem_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/smem_tcfg_latch.sv
module smem_tcfg_latch
  import smem_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap,
  input  logic [PH_W-1:0] aset,
  input  logic [PH_W-1:0] ahld,
  input  logic [PH_W-1:0] dset,
  input  logic [PH_W-1:0] turn,
  output tcfg_t           cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cfg <= '0;
    else if (cap) cfg <= '{aset: aset, ahld: ahld, dset: dset, turn: turn};
  end
endmodule

// File: rtl/smem_seq.sv
module smem_seq
  import smem_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  input  logic [PH_W-1:0]  cfg_adr_setup,
  input  logic [PH_W-1:0]  cfg_adr_hold,
  input  logic [PH_W-1:0]  cfg_dat_setup,
  input  logic [PH_W-1:0]  cfg_turnaround,
  input  logic [GAP_W-1:0] cfg_rr_gap,
  input  logic [GAP_W-1:0] cfg_ww_gap,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_dout,
  output logic             mem_dout_en,
  input  logic [DW-1:0]    mem_din,
  output logic             mem_cs_n,
  output logic             mem_oe_n,
  output logic             mem_we_n
);
  // reset: asserted asynchronously, released after two clock edges
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rst_m} <= 2'b00;
    else        {rst_s, rst_m} <= {rst_m, 1'b1};
  end

  phase_e            st_q, st_d;
  logic              acc, gap_need, ld, cnt_zero, cap_rd;
  logic [GAP_W-1:0]  ldv;
  tcfg_t             cfg_q;
  logic              have_prev_q, last_wr_q, wr_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q, rdata_q;
  logic              rdv_q;

  assign acc      = (st_q == PH_IDLE) && req_valid;
  assign gap_need = have_prev_q && (req_write == last_wr_q);
  assign cap_rd   = (st_q == PH_DATA) && cnt_zero && !wr_q;

  smem_tcfg_latch u_cfg (
    .clk (clk), .rst_n (rst_s), .cap (acc),
    .aset (cfg_adr_setup), .ahld (cfg_adr_hold),
    .dset (cfg_dat_setup), .turn (cfg_turnaround),
    .cfg (cfg_q)
  );

  smem_down_cnt #(.W(GAP_W)) u_cnt (
    .clk (clk), .rst_n (rst_s), .load (ld), .load_val (ldv), .zero (cnt_zero)
  );

  // next-state and counter reload
  always_comb begin
    st_d = st_q;
    ld   = 1'b0;
    ldv  = '0;
    unique case (st_q)
      PH_IDLE: if (req_valid) begin
        ld = 1'b1;
        if (gap_need) begin
          st_d = PH_GAP;
          ldv  = req_write ? cfg_ww_gap : cfg_rr_gap;
        end else begin
          st_d = PH_ASET;
          ldv  = zx(cfg_adr_setup);
        end
      end
      PH_GAP:  if (cnt_zero) begin st_d = PH_ASET; ld = 1'b1; ldv = zx(cfg_q.aset); end
      PH_ASET: if (cnt_zero) begin st_d = PH_AHLD; ld = 1'b1; ldv = zx(cfg_q.ahld); end
      PH_AHLD: if (cnt_zero) begin st_d = PH_DATA; ld = 1'b1; ldv = zx(cfg_q.dset); end
      PH_DATA: if (cnt_zero) begin st_d = PH_TURN; ld = 1'b1; ldv = zx(cfg_q.turn); end
      PH_TURN: if (cnt_zero) st_d = PH_IDLE;
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) st_q <= PH_IDLE;
    else        st_q <= st_d;
  end

  // request capture
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      have_prev_q <= 1'b0;
      last_wr_q   <= 1'b0;
      wr_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
    end else if (acc) begin
      have_prev_q <= 1'b1;
      last_wr_q   <= req_write;
      wr_q        <= req_write;
      addr_q      <= req_addr;
      wdata_q     <= req_wdata;
    end
  end

  // read data capture
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      rdata_q <= '0;
    else if (cap_rd) rdata_q <= mem_din;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) rdv_q <= 1'b0;
    else        rdv_q <= cap_rd;
  end

  assign req_ready   = (st_q == PH_IDLE);
  assign rd_valid    = rdv_q;
  assign rd_data     = rdata_q;
  assign mem_addr    = addr_q;
  assign mem_dout    = wdata_q;
  assign mem_cs_n    = !((st_q == PH_ASET) || (st_q == PH_AHLD) || (st_q == PH_DATA));
  assign mem_oe_n    = !((st_q == PH_DATA) && !wr_q);
  assign mem_we_n    = !((st_q == PH_DATA) && wr_q);
  assign mem_dout_en = wr_q && !mem_cs_n;

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_oe_n || mem_we_n) && (mem_cs_n -> (mem_oe_n && mem_we_n)));
  // R6
  we_drive_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !mem_we_n |-> mem_dout_en);
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!mem_cs_n && !req_ready) |=> (mem_cs_n || $stable(mem_addr)));
  // R5
  rdv_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_s)
    rd_valid |-> ($past(!mem_oe_n) && mem_oe_n));
  // R11
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (req_ready && req_valid) |=> !req_ready);
endmodule

// File: tb/sim_smem_seq.sv
module sim_smem_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_addr, req_wdata;
  logic        req_ready, rd_valid;
  logic [15:0] rd_data;
  logic [3:0]  c_as, c_ah, c_ds, c_tu;
  logic [7:0]  c_gr, c_gw;
  logic [15:0] mem_addr, mem_dout, mem_din;
  logic        mem_dout_en, mem_cs_n, mem_oe_n, mem_we_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  assign mem_din = mem_addr ^ 16'h5A3C;

  smem_seq u0 (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .req_ready (req_ready), .rd_valid (rd_valid), .rd_data (rd_data),
    .cfg_adr_setup (c_as), .cfg_adr_hold (c_ah),
    .cfg_dat_setup (c_ds), .cfg_turnaround (c_tu),
    .cfg_rr_gap (c_gr), .cfg_ww_gap (c_gw),
    .mem_addr (mem_addr), .mem_dout (mem_dout), .mem_dout_en (mem_dout_en),
    .mem_din (mem_din), .mem_cs_n (mem_cs_n), .mem_oe_n (mem_oe_n), .mem_we_n (mem_we_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // one access; exp_pre = idle cycles expected before chip-select
  task automatic access(input bit wr, input logic [15:0] addr, input logic [15:0] wd,
                        input int a, input int h, input int d, input int t,
                        input int gr, input int gw, input int exp_pre);
    int pre = 0, cs = 0, post = 0, str = 0, str_first = -1;
    int rdv = 0, rd_bad = 0, addr_bad = 0, dout_bad = 0, other_bad = 0, rd_pos = -1;
    @(negedge clk);
    chk("R11 ready before accept", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    c_as = 4'(a); c_ah = 4'(h); c_ds = 4'(d); c_tu = 4'(t);
    c_gr = 8'(gr); c_gw = 8'(gw);
    @(negedge clk);
    req_valid = 1'b0;
    // R10: change every timing input after acceptance
    c_as = ~c_as; c_ah = ~c_ah; c_ds = ~c_ds; c_tu = ~c_tu;
    c_gr = ~c_gr; c_gw = ~c_gw;
    for (int i = 0; i < 2000 && !req_ready; i++) begin
      if (rd_valid) begin
        rdv++;
        rd_pos = post;
        if (rd_data != (addr ^ 16'h5A3C)) rd_bad++;
      end
      if (mem_cs_n) begin
        if (cs == 0) pre++; else post++;
        if (!mem_oe_n || !mem_we_n) other_bad++;
      end else begin
        cs++;
        if (mem_addr != addr) addr_bad++;
        if (wr && (mem_dout != wd || !mem_dout_en)) dout_bad++;
        if (!wr && mem_dout_en) dout_bad++;
        if ((wr ? mem_we_n : mem_oe_n) == 1'b0) begin
          if (str_first < 0) str_first = cs - 1;
          str++;
        end
        if ((wr ? mem_oe_n : mem_we_n) == 1'b0) other_bad++;
      end
      @(negedge clk);
    end
    chk(exp_pre == 0 ? "R9 no gap" : (wr ? "R8 ww gap" : "R7 rr gap"), pre, exp_pre);
    chk("R2 cs window", cs, a + h + d + 3);
    chk("R2 addr stable", addr_bad, 0);
    chk("R3 strobe length", str, d + 1);
    chk("R3 strobe position", str_first, a + h + 2);
    chk("R3 wrong strobe", other_bad, 0);
    chk("R4 R11 turnaround", post, t + 1);
    chk("R6 write data", dout_bad, 0);
    if (!wr) begin
      chk("R5 rd_valid pulses", rdv, 1);
      chk("R5 rd_valid cycle", rd_pos, 0);
      chk("R5 rd_data", rd_bad, 0);
    end else begin
      chk("R5 no rd_valid on write", rdv, 0);
    end
  endtask

  initial begin
    int k;
    int gaps[5] = '{0, 1, 8, 37, 255};
    int asv[3]  = '{0, 1, 15};
    int ahv[3]  = '{0, 2, 15};
    int dsv[3]  = '{0, 3, 15};
    int tuv[2]  = '{0, 15};
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    c_as = '0; c_ah = '0; c_ds = '0; c_tu = '0; c_gr = 8'd8; c_gw = 8'd8;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 ready", req_ready, 1);
    chk("R1 cs_n", mem_cs_n, 1);
    chk("R1 oe_n", mem_oe_n, 1);
    chk("R1 we_n", mem_we_n, 1);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 dout_en", mem_dout_en, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ready after release", req_ready, 1);
    chk("R1 cs_n after release", mem_cs_n, 1);

    // phase sweep, alternating direction: no gap phase (first is a read)
    k = 0;
    foreach (asv[i]) foreach (ahv[j]) foreach (dsv[m]) foreach (tuv[n]) begin
      access(k[0], 16'(16'h1000 + k * 7), 16'(16'hC000 + k * 13),
             asv[i], ahv[j], dsv[m], tuv[n], 200, 150, 0);
      k++;
    end

    // gap sweep; the last access of the phase sweep was a write (k odd count)
    foreach (gaps[g]) begin
      access(1'b0, 16'h2222, 16'h0, 1, 0, 2, 1, 3, 90, 0);
      access(1'b0, 16'h2345, 16'h0, 0, 1, 1, 0, gaps[g], 255 - gaps[g], gaps[g] + 1);
      access(1'b1, 16'h3456, 16'hBEEF, 2, 1, 0, 2, 77, 5, 0);
      access(1'b1, 16'h4567, 16'hF00D, 0, 0, 3, 1, 255 - gaps[g], gaps[g], gaps[g] + 1);
      access(1'b0, 16'h5678, 16'h0, 0, 0, 0, 0, 12, 12, 0);
      access(1'b1, 16'h6789, 16'h1234, 0, 0, 0, 0, 12, 12, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule